// File: doc/BRIEF.md
# Prescaled Timer with Compare-Match Blocking

This block is a synchronous up-counter for a microcontroller-class subsystem. The counter moves forward only on timer ticks. A small prescaler produces those ticks: it can be stopped, run every system clock, or run every eighth system clock. One or two compare channels watch the count. Each channel raises its own flag when the count meets the channel's compare value. An overflow flag records each wrap of the count from its all-ones value to zero. A mode input selects one of two behaviours. In free-running mode the count wraps through the full range. In clear-on-match mode the count returns to zero once it reaches the value in compare channel A.

A CPU write port loads the counter, loads the compare values and clears flags. The port uses write-one-to-clear for flags. Separate acknowledge inputs let an interrupt controller clear a flag once it has serviced it. Any CPU load of the counter suppresses compare matches on the next timer tick. Software can therefore set the count equal to a compare value without raising a flag. This holds even when the load happens while the prescaler is stopped.

Top module: `match_block_timer`

## Requirements
- R1: After synchronous reset, count, overflow flag and all compare flags read 0, and every compare value is 0.
- R2: The count is unchanged when clk_sel is 0 or 3. With clk_sel 1 it advances once per clock. With clk_sel 2 it advances exactly once every 8 clocks.
- R3: In free-running mode (mode 0), a tick at count all-ones moves the count to 0 and sets ovf_flag.
- R4: A tick taken while the count equals channel i's compare value sets cmp_flag[i] at that same clock edge. The flag is never set between ticks. Each channel acts independently of the other.
- R5: In clear-on-match mode (mode 1), a tick at count equal to compare value A loads 0 and sets cmp_flag[0]. The count never passes that value.
- R6: A write to address 0 loads wr_data into the count. Compare matches are suppressed on any tick in the same cycle as the write and on the first tick after it, even when that tick follows a stopped period.
- R7: A write to address 3 clears the flags whose data bits are 1 (bit 0 overflow, bit 1 channel A, bit 2 channel B) and leaves the others untouched. ack_ovf and ack_cmp[i] each clear their own flag.
- R8: When a flag is set and cleared in the same cycle, the flag ends up set.
- R9: A counter write takes priority over a tick in the same cycle. The count takes the written value and ovf_flag is not set by that tick.
- R10: Writes to address 1 and 2 load compare values A and B, which then govern R4 and R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | CPU write strobe |
| wr_addr | input | 2 | 0 count, 1 compare A, 2 compare B, 3 flag clear |
| wr_data | input | CNT_W | CPU write data |
| mode | input | 1 | 0 free-running, 1 clear-on-match A |
| clk_sel | input | 2 | 0 stop, 1 every clock, 2 every 8 clocks, 3 stop |
| ack_ovf | input | 1 | Service acknowledge, clears overflow flag |
| ack_cmp | input | NUM_CH | Service acknowledge per compare channel |
| count | output | CNT_W | Current count |
| ovf_flag | output | 1 | Overflow flag |
| cmp_flag | output | NUM_CH | Compare flag per channel |

## Verification
The bench sweeps compare values across the range, including 0 and all-ones. It checks that each flag rises exactly on the edge where the count leaves the compare value. A design that compared the next count instead of the current one would flag one tick early. The blocking cases load the count equal to compare A, both while running and after a stopped interval. A design that forgot the block would raise a flag immediately, and one that dropped it on stop would lose the protection. Further cases cover the clear-on-match period, the divide-by-8 tick spacing, a set colliding with a clear, and a load colliding with a wrap. Each of these shows up as a wrong period, a flag raised mid-period, a lost flag, or a spurious overflow.

// File: rtl/mbt_pkg.sv
package mbt_pkg;
  typedef enum logic [1:0] {
    CLK_STOP = 2'd0,
    CLK_DIV1 = 2'd1,
    CLK_DIV8 = 2'd2,
    CLK_OFF  = 2'd3
  } clk_sel_e;

  typedef enum logic {
    MODE_FREE  = 1'b0,
    MODE_CLEAR = 1'b1
  } mode_e;

  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_COUNT = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CMP_A = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_FLAGS = 2'd3;
endpackage

// File: rtl/mbt_prescaler.sv
module mbt_prescaler
  import mbt_pkg::*;
#(
  parameter int DIV = 8
) (
  input  logic     clk,
  input  logic     rst,
  input  clk_sel_e sel_i,
  output logic     tick_o
);
  localparam int PHASE_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PHASE_W-1:0] LAST = PHASE_W'(DIV - 1);

  logic [PHASE_W-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (rst)                 phase_q <= '0;
    else if (phase_q == LAST) phase_q <= '0;
    else                     phase_q <= phase_q + 1'b1;
  end

  always_comb begin
    unique case (sel_i)
      CLK_DIV1: tick_o = 1'b1;
      CLK_DIV8: tick_o = (phase_q == LAST);
      default:  tick_o = 1'b0;
    endcase
  end

  // divided ticks are isolated: never two in a row
  assert_div_spacing_R2: assert property (@(posedge clk) disable iff (rst)
    (sel_i == CLK_DIV8 && tick_o) |=> !(sel_i == CLK_DIV8 && tick_o));
  assert_stop_no_tick_R2: assert property (@(posedge clk) disable iff (rst)
    (sel_i == CLK_STOP || sel_i == CLK_OFF) |-> !tick_o);
endmodule

// File: rtl/mbt_counter.sv
module mbt_counter
  import mbt_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  mode_e            mode_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             top_hit_i,
  input  logic             ovf_clr_i,
  output logic [CNT_W-1:0] count_o,
  output logic             ovf_o,
  output logic             block_o
);
  localparam logic [CNT_W-1:0] MAX_VAL = '1;

  logic block_q;
  logic at_max;

  assign at_max  = (count_o == MAX_VAL);
  assign block_o = block_q | load_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      count_o <= '0;
      block_q <= 1'b0;
    end else begin
      if (load_i)
        count_o <= load_val_i;
      else if (tick_i)
        count_o <= (mode_i == MODE_CLEAR && top_hit_i) ? '0 : count_o + 1'b1;
      if (load_i)      block_q <= 1'b1;
      else if (tick_i) block_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                            ovf_o <= 1'b0;
    else if (tick_i && !load_i && at_max) ovf_o <= 1'b1;
    else if (ovf_clr_i)                 ovf_o <= 1'b0;
  end

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!tick_i && !load_i) |=> $stable(count_o));
  assert_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    (tick_i && !load_i && at_max) |=> (count_o == '0 && ovf_o));
  assert_clear_top_R5: assert property (@(posedge clk) disable iff (rst)
    (mode_i == MODE_CLEAR && tick_i && !load_i && top_hit_i) |=> count_o == '0);
  assert_load_R6: assert property (@(posedge clk) disable iff (rst)
    load_i |=> count_o == $past(load_val_i));
  assert_load_no_ovf_R9: assert property (@(posedge clk) disable iff (rst)
    (load_i && !ovf_o) |=> !ovf_o);
endmodule

// File: rtl/mbt_channel.sv
module mbt_channel #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             block_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             ref_wr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             clr_i,
  output logic             match_o,
  output logic             flag_o
);
  logic [CNT_W-1:0] ref_q;
  logic             hit;

  assign match_o = (count_i == ref_q);
  assign hit     = tick_i && match_o && !block_i;

  always_ff @(posedge clk) begin
    if (rst)           ref_q <= '0;
    else if (ref_wr_i) ref_q <= wr_data_i;
  end

  always_ff @(posedge clk) begin
    if (rst)        flag_o <= 1'b0;
    else if (hit)   flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end

  // a hit wins over a same-cycle clear (R8) and is visible next cycle (R4)
  assert_hit_sets_R4_R8: assert property (@(posedge clk) disable iff (rst)
    (tick_i && match_o && !block_i) |=> flag_o);
  assert_blocked_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    (block_i && !flag_o) |=> !flag_o);
  assert_no_mid_period_R4: assert property (@(posedge clk) disable iff (rst)
    (!tick_i && !flag_o) |=> !flag_o);
endmodule

// File: rtl/match_block_timer.sv
module match_block_timer
  import mbt_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int NUM_CH = 2,
  parameter int DIV    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              mode,
  input  logic [1:0]        clk_sel,
  input  logic              ack_ovf,
  input  logic [NUM_CH-1:0] ack_cmp,
  output logic [CNT_W-1:0]  count,
  output logic              ovf_flag,
  output logic [NUM_CH-1:0] cmp_flag
);
  logic              tick;
  logic              block;
  logic              load;
  logic              flag_wr;
  logic [NUM_CH-1:0] match;

  assign load    = wr_en && (wr_addr == ADDR_COUNT);
  assign flag_wr = wr_en && (wr_addr == ADDR_FLAGS);

  mbt_prescaler #(.DIV(DIV)) u_presc (
    .clk    (clk),
    .rst    (rst),
    .sel_i  (clk_sel_e'(clk_sel)),
    .tick_o (tick)
  );

  mbt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .tick_i     (tick),
    .mode_i     (mode_e'(mode)),
    .load_i     (load),
    .load_val_i (wr_data),
    .top_hit_i  (match[0] && !block),
    .ovf_clr_i  (ack_ovf || (flag_wr && wr_data[0])),
    .count_o    (count),
    .ovf_o      (ovf_flag),
    .block_o    (block)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    mbt_channel #(.CNT_W(CNT_W)) u_ch (
      .clk       (clk),
      .rst       (rst),
      .tick_i    (tick),
      .block_i   (block),
      .count_i   (count),
      .ref_wr_i  (wr_en && (wr_addr == ADDR_CMP_A + 2'(i))),
      .wr_data_i (wr_data),
      .clr_i     (ack_cmp[i] || (flag_wr && wr_data[1+i])),
      .match_o   (match[i]),
      .flag_o    (cmp_flag[i])
    );
  end

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (count == '0 && !ovf_flag && cmp_flag == '0));
endmodule

// File: tb/match_block_timer_tb.sv
module match_block_timer_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       mode = 1'b0;
  logic [1:0] clk_sel = 2'd0;
  logic       ack_ovf = 1'b0;
  logic [1:0] ack_cmp = '0;
  logic [7:0] count;
  logic       ovf_flag;
  logic [1:0] cmp_flag;
  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  match_block_timer u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .mode(mode), .clk_sel(clk_sel), .ack_ovf(ack_ovf), .ack_cmp(ack_cmp),
    .count(count), .ovf_flag(ovf_flag), .cmp_flag(cmp_flag)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cpu_wr(logic [1:0] a, logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk); step(); rst = 1'b0;
    // R1 reset state
    check("R1 count", count, 0);
    check("R1 ovf", ovf_flag, 0);
    check("R1 cmp", cmp_flag, 0);
    // R1/R10: reset compare value A is 0, so first div1 tick from count 0 flags A
    clk_sel = 2'd1; step();
    check("R1 R10 zero ref flags A", cmp_flag[0], 1);
    clk_sel = 2'd0;
    // R2 stopped
    cpu_wr(2'd0, 8'd7);
    repeat (20) step();
    check("R2 stopped hold", count, 7);
    clk_sel = 2'd3; repeat (5) step();
    check("R2 code 3 hold", count, 7);

    // R4/R10 sweep of compare values on both channels, div1, free mode
    for (int v = 0; v < 256; v += 17) begin
      automatic int vb = (v + 100) % 256;
      clk_sel = 2'd0;
      cpu_wr(2'd1, 8'(v));
      cpu_wr(2'd2, 8'(vb));
      cpu_wr(2'd3, 8'h07);
      cpu_wr(2'd0, 8'((v + 253) % 256));
      clk_sel = 2'd1;
      repeat (3) step();
      check("R4 no early flag A", cmp_flag[0], 0);
      step();
      check("R4 count past ref", count, (v + 1) % 256);
      check("R4 flag A on leaving ref", cmp_flag[0], 1);
      check("R4 channel B independent", cmp_flag[1], 0);
    end
    // last v=255: wrap happened => R3
    check("R3 ovf after wrap", ovf_flag, 1);

    // R3 wrap in free mode, plus R7 selective clear
    clk_sel = 2'd0;
    cpu_wr(2'd3, 8'h07);
    cpu_wr(2'd0, 8'd254);
    clk_sel = 2'd1;
    step();
    check("R3 no ovf before max", ovf_flag, 0);
    step();
    check("R3 wraps to 0", count, 0);
    check("R3 ovf set", ovf_flag, 1);
    clk_sel = 2'd0;
    cpu_wr(2'd1, 8'd20); cpu_wr(2'd2, 8'd20);
    cpu_wr(2'd0, 8'd19);
    clk_sel = 2'd1; step(); step(); clk_sel = 2'd0;
    check("R4 both flags", cmp_flag, 3);
    cpu_wr(2'd3, 8'h02);
    check("R7 clear A only", cmp_flag, 2);
    check("R7 ovf untouched", ovf_flag, 1);
    ack_ovf = 1'b1; step(); ack_ovf = 1'b0;
    check("R7 ack ovf", ovf_flag, 0);
    check("R7 ack leaves B", cmp_flag[1], 1);
    ack_cmp = 2'b10; step(); ack_cmp = 2'b00;
    check("R7 ack B", cmp_flag[1], 0);

    // R6 blocking while running and after a stopped interval
    cpu_wr(2'd1, 8'd50);
    cpu_wr(2'd0, 8'd50);
    clk_sel = 2'd1; step(); clk_sel = 2'd0;
    check("R6 blocked count", count, 51);
    check("R6 blocked flag", cmp_flag[0], 0);
    cpu_wr(2'd0, 8'd50);
    repeat (12) step();
    clk_sel = 2'd1; step(); clk_sel = 2'd0;
    check("R6 blocked after stop", cmp_flag[0], 0);
    cpu_wr(2'd0, 8'd49);
    clk_sel = 2'd1; step(); step(); clk_sel = 2'd0;
    check("R6 unblocked control", cmp_flag[0], 1);
    cpu_wr(2'd3, 8'h07);
    // R6 write while running: the write's tick is blocked too
    clk_sel = 2'd1;
    cpu_wr(2'd0, 8'd50);
    check("R6 running load", count, 50);
    step();
    check("R6 running blocked", cmp_flag[0], 0);
    check("R6 running count", count, 51);

    // R9 load beats tick at max
    clk_sel = 2'd0;
    cpu_wr(2'd0, 8'd255);
    cpu_wr(2'd3, 8'h07);
    clk_sel = 2'd1;
    cpu_wr(2'd0, 8'd10);
    check("R9 load wins", count, 10);
    check("R9 no ovf", ovf_flag, 0);

    // R8 set beats clear: ref B = 30, clear B in the tick where count==30
    clk_sel = 2'd0;
    cpu_wr(2'd2, 8'd30);
    cpu_wr(2'd3, 8'h07);
    cpu_wr(2'd0, 8'd28);
    clk_sel = 2'd1;
    step(); step();
    check("R8 at ref", count, 30);
    ack_cmp = 2'b10; step(); ack_cmp = 2'b00;
    check("R8 set wins over ack", cmp_flag[1], 1);
    clk_sel = 2'd0;

    // R5 clear-on-match period
    mode = 1'b1;
    cpu_wr(2'd1, 8'd9);
    cpu_wr(2'd3, 8'h07);
    cpu_wr(2'd0, 8'd0);
    clk_sel = 2'd1;
    begin
      automatic int bad = 0;
      automatic int first_flag = -1;
      for (int k = 1; k <= 50; k++) begin
        step();
        if (count != k % 10) bad++;
        if (cmp_flag[0] && first_flag < 0) first_flag = k;
      end
      check("R5 period of ten", bad, 0);
      check("R5 flag on clear", first_flag, 10);
      check("R5 no ovf", ovf_flag, 0);
    end
    clk_sel = 2'd0;
    mode = 1'b0;

    // R2/R4 divide by 8 spacing and flag alignment
    cpu_wr(2'd2, 8'd3);
    cpu_wr(2'd3, 8'h07);
    cpu_wr(2'd0, 8'd0);
    clk_sel = 2'd2;
    begin
      automatic int changes = 0;
      automatic int last = -1;
      automatic int bad_gap = 0;
      automatic int bad_flag = 0;
      automatic int prev = count;
      automatic int prevf = 0;
      for (int k = 0; k < 80; k++) begin
        step();
        if (count != prev) begin
          if (last >= 0 && k - last != 8) bad_gap++;
          last = k; changes++;
        end
        if (cmp_flag[1] && !prevf && !(prev == 3 && count == 4)) bad_flag++;
        prev = count; prevf = cmp_flag[1];
      end
      check("R2 div8 tick count", changes, 10);
      check("R2 div8 spacing", bad_gap, 0);
      check("R4 div8 flag on tick", bad_flag, 0);
      check("R4 div8 flag set", cmp_flag[1], 1);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule